// File: doc/BRIEF.md
# Flash Address Protected-Range Checker

This block sits in front of a serial-flash cycle engine and decides, for every flash cycle the engine wants to issue, whether that cycle may go ahead. It holds a small bank of protected-range words. Each word describes one window of the flash address space with 4 KB granularity and carries two independent enables: one that guards reads, and one that guards both programming and erase.

A request consists of a start address, an access kind and a byte count. The block tests every byte the request would touch against every enabled window of the matching kind. One clock later it answers with a one-cycle grant pulse or a one-cycle blocked pulse. The cycle engine converts the blocked pulse into a cycle error.

Software programs and reads back the range words through a simple indexed port. A lock input freezes the whole bank. Once the lock has been seen, the bank stays frozen until reset.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, every range word reads back as zero, both decision outputs are low, and the bank is unlocked.
- R2: Range words are selected by an index from 0 to 4. In each word, bit 31 is the write/erase protect enable, bit 15 is the read protect enable, bits [28:16] hold the upper limit page and bits [12:0] hold the lower limit page. A write to index 5, 6 or 7 is ignored, and reading any of those indexes returns zero.
- R3: Bits 30:29 and 14:13 of every range word read as zero, whatever value was written to them.
- R4: Every cycle with req_valid high is answered in the following cycle by exactly one of grant_o or block_o, held high for that one cycle. Both outputs stay low in every other cycle.
- R5: req_kind encodes the access as 0 = read, 1 = program, 2 = erase, 3 = other modifying access. A read is checked only against the read protect enables. Every other kind is checked only against the write/erase protect enables.
- R6: A window runs inclusively from the lower limit page with address bits [11:0] equal to 0x000, up to the upper limit page with address bits [11:0] equal to 0xFFF.
- R7: A request is blocked when any byte from req_addr to req_addr + req_len - 1 lies inside an enabled window of the matching kind. A request with req_len of zero touches no byte and is always granted.
- R8: A window whose upper limit page is below its lower limit page is empty and blocks nothing.
- R9: Asserting lock_in in any cycle freezes all range words from that cycle onward, including a write presented in the same cycle. The freeze lasts until reset, even after lock_in is released.
- R10: A request presented in the same cycle as a range-word write is judged against the range contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Freezes the range bank until reset |
| reg_wr_en | input | 1 | Range word write strobe |
| reg_wr_idx | input | 3 | Index of the range word to write |
| reg_wdata | input | 32 | Range word write value |
| reg_rd_idx | input | 3 | Index of the range word to read back |
| reg_rdata | output | 32 | Read-back value of the selected range word |
| req_valid | input | 1 | Cycle request strobe |
| req_addr | input | 24 | Start byte address of the requested cycle |
| req_kind | input | 2 | Access kind: 0 read, 1 program, 2 erase, 3 other modifying |
| req_len | input | 7 | Number of bytes the cycle touches |
| grant_o | output | 1 | Cycle allowed, one clock after the request |
| block_o | output | 1 | Cycle refused, one clock after the request |

## Verification
Some properties are checked by assertions on every cycle:
- the grant and blocked pulses never overlap, every request gets exactly one answer, and no answer appears without a request;
- a zero-length request is always granted;
- reserved bits always read as zero, and unmapped indexes always read as zero;
- the read-back value never changes once the lock has been seen.

The actual window arithmetic can only be shown by the bench scenarios. Against its behavioural model, the bench covers:
- bytes just inside and just outside each page bound, including multi-byte requests that straddle a bound;
- the split between the read enable and the write/erase enable;
- inverted windows and the top of the address space;
- a write and a request landing in the same cycle, and a write landing in the cycle the lock arrives.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int WORD_W = 32;
    localparam int PAGE_W = 12;
    localparam int LIM_W  = 13;
    localparam int SPAN_W = PAGE_W + LIM_W;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_PROG  = 2'd1,
        KIND_ERASE = 2'd2,
        KIND_OTHER = 2'd3
    } kind_e;

    typedef struct packed {
        logic             wr_prot;
        logic             rd_prot;
        logic [LIM_W-1:0] hi_page;
        logic [LIM_W-1:0] lo_page;
    } range_t;

    // Unpack a software word; reserved bits are simply not kept.
    function automatic range_t word_to_range(logic [WORD_W-1:0] w);
        range_t r;
        r.wr_prot = w[31];
        r.rd_prot = w[15];
        r.hi_page = w[28:16];
        r.lo_page = w[12:0];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] range_to_word(range_t r);
        return {r.wr_prot, 2'b00, r.hi_page, r.rd_prot, 2'b00, r.lo_page};
    endfunction

    // Reads use the read enable; every other kind uses the write/erase enable.
    function automatic logic prot_applies(range_t r, kind_e k);
        return (k == KIND_READ) ? r.rd_prot : r.wr_prot;
    endfunction

endpackage

// File: rtl/fpr_range_bank.sv
module fpr_range_bank
    import fpr_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int IDX_W      = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           lock_in,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [WORD_W-1:0]              rd_data,
    output range_t [NUM_RANGES-1:0]        ranges_o
);

    logic   locked_q;
    logic   frozen;
    range_t [NUM_RANGES-1:0] ranges_q;

    assign frozen = locked_q | lock_in;

    always_ff @(posedge clk) begin
        if (rst)
            locked_q <= 1'b0;
        else if (lock_in)
            locked_q <= 1'b1;
    end

    for (genvar gi = 0; gi < NUM_RANGES; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                ranges_q[gi] <= '0;
            else if (wr_en && !frozen && (wr_idx == IDX_W'(gi)))
                ranges_q[gi] <= word_to_range(wr_data);
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_data = range_to_word(ranges_q[i]);
        end
    end

    assign ranges_o = ranges_q;

endmodule

// File: rtl/fpr_window_match.sv
module fpr_window_match
    import fpr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 7
) (
    input  range_t              rng,
    input  kind_e               kind,
    input  logic [ADDR_W-1:0]   start,
    input  logic [LEN_W-1:0]    len,
    output logic                hit
);

    localparam int BASE_W = (SPAN_W > ADDR_W) ? SPAN_W : ADDR_W;
    localparam int CALC_W = ((BASE_W > LEN_W) ? BASE_W : LEN_W) + 1;

    logic [CALC_W-1:0] first_b;
    logic [CALC_W-1:0] last_b;
    logic [CALC_W-1:0] lo_b;
    logic [CALC_W-1:0] hi_b;
    logic              nonempty;
    logic              overlap;

    always_comb begin
        first_b  = CALC_W'(start);
        last_b   = first_b + CALC_W'(len) - CALC_W'(1);
        lo_b     = CALC_W'({rng.lo_page, {PAGE_W{1'b0}}});
        hi_b     = CALC_W'({rng.hi_page, {PAGE_W{1'b1}}});
        nonempty = (lo_b <= hi_b);
        overlap  = (first_b <= hi_b) && (last_b >= lo_b);
        hit      = (len != '0) && prot_applies(rng, kind) && nonempty && overlap;
    end

endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
    import fpr_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 7,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES + 1) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lock_in,
    input  logic               reg_wr_en,
    input  logic [IDX_W-1:0]   reg_wr_idx,
    input  logic [31:0]        reg_wdata,
    input  logic [IDX_W-1:0]   reg_rd_idx,
    output logic [31:0]        reg_rdata,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_kind,
    input  logic [LEN_W-1:0]   req_len,
    output logic               grant_o,
    output logic               block_o
);

    range_t [NUM_RANGES-1:0] ranges;
    logic   [NUM_RANGES-1:0] hits;
    logic                    any_hit;
    kind_e                   kind;
    logic                    grant_q;
    logic                    block_q;

    assign kind = kind_e'(req_kind);

    fpr_range_bank #(
        .NUM_RANGES (NUM_RANGES),
        .IDX_W      (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .lock_in  (lock_in),
        .wr_en    (reg_wr_en),
        .wr_idx   (reg_wr_idx),
        .wr_data  (reg_wdata),
        .rd_idx   (reg_rd_idx),
        .rd_data  (reg_rdata),
        .ranges_o (ranges)
    );

    for (genvar gi = 0; gi < NUM_RANGES; gi++) begin : g_match
        fpr_window_match #(
            .ADDR_W (ADDR_W),
            .LEN_W  (LEN_W)
        ) u_match (
            .rng   (ranges[gi]),
            .kind  (kind),
            .start (req_addr),
            .len   (req_len),
            .hit   (hits[gi])
        );
    end

    assign any_hit = |hits;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= 1'b0;
            block_q <= 1'b0;
        end else begin
            grant_q <= req_valid && !any_hit;
            block_q <= req_valid && any_hit;
        end
    end

    assign grant_o = grant_q;
    assign block_o = block_q;

endmodule

// File: rtl/flash_range_guard_chk.sv
module flash_range_guard_chk #(
    parameter int NUM_RANGES = 5,
    parameter int LEN_W      = 7,
    parameter int IDX_W      = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             lock_in,
    input logic [IDX_W-1:0] reg_rd_idx,
    input logic [31:0]      reg_rdata,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             grant_o,
    input logic             block_o
);

    logic lock_seen;

    always_ff @(posedge clk) begin
        if (rst)
            lock_seen <= 1'b0;
        else if (lock_in)
            lock_seen <= 1'b1;
    end

    // R4
    single_answer_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant_o && block_o));

    // R4
    answered_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (grant_o || block_o));

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o || block_o) |-> $past(req_valid));

    // R7
    empty_len_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_len == '0)) |=> grant_o);

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[30:29] == 2'b00) && (reg_rdata[14:13] == 2'b00));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(reg_rd_idx) >= NUM_RANGES) |-> (reg_rdata == 32'h0));

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_seen && $stable(reg_rd_idx)) |-> $stable(reg_rdata));

endmodule

bind flash_range_guard flash_range_guard_chk #(
    .NUM_RANGES (NUM_RANGES),
    .LEN_W      (LEN_W),
    .IDX_W      (IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lock_in    (lock_in),
    .reg_rd_idx (reg_rd_idx),
    .reg_rdata  (reg_rdata),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .grant_o    (grant_o),
    .block_o    (block_o)
);

// File: tb/tb_flash_range_guard.sv
module tb_flash_range_guard;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NR         = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock_in = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_rd_idx = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [6:0]  req_len = '0;
    logic        grant_o;
    logic        block_o;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    // Reference model state
    logic [31:0] m_reg [NR];
    bit          m_lock;
    bit          exp_grant;
    bit          exp_block;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_range_guard dut (
        .clk        (clk),
        .rst        (rst),
        .lock_in    (lock_in),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_idx (reg_wr_idx),
        .reg_wdata  (reg_wdata),
        .reg_rd_idx (reg_rd_idx),
        .reg_rdata  (reg_rdata),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_kind   (req_kind),
        .req_len    (req_len),
        .grant_o    (grant_o),
        .block_o    (block_o)
    );

    // Behavioural reference: decide on old contents, then apply the write.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) m_reg[i] = 32'h0;
            m_lock    = 1'b0;
            exp_grant = 1'b0;
            exp_block = 1'b0;
        end else begin
            bit hit;
            hit = 1'b0;
            if (req_valid && req_len != 0) begin
                for (int i = 0; i < NR; i++) begin
                    longint lo, hi, s, e;
                    bit en;
                    en = (req_kind == 2'd0) ? m_reg[i][15] : m_reg[i][31];
                    lo = longint'(m_reg[i][12:0]) * 4096;
                    hi = longint'(m_reg[i][28:16]) * 4096 + 4095;
                    s  = longint'(req_addr);
                    e  = s + longint'(req_len) - 1;
                    if (en && lo <= hi && s <= hi && e >= lo) hit = 1'b1;
                end
            end
            exp_grant = req_valid && !hit;
            exp_block = req_valid && hit;
            if (reg_wr_en && !m_lock && !lock_in && reg_wr_idx < NR)
                m_reg[reg_wr_idx] = reg_wdata & 32'h9FFF_9FFF;
            if (lock_in) m_lock = 1'b1;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    // Compare against the model on every clock, a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        chk("grant_o", {31'b0, grant_o}, {31'b0, exp_grant});
        chk("block_o", {31'b0, block_o}, {31'b0, exp_block});
        chk("reg_rdata", reg_rdata, (reg_rd_idx < NR) ? m_reg[reg_rd_idx] : 32'h0);
    end

    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en  = 1'b1;
        reg_wr_idx = idx;
        reg_wdata  = data;
        reg_rd_idx = idx;
        @(negedge clk);
        reg_wr_en  = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx);
        @(negedge clk);
        reg_rd_idx = idx;
        @(negedge clk);
    endtask

    task automatic rq(input logic [23:0] a, input logic [1:0] k, input logic [6:0] n);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_kind  = k;
        req_len   = n;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state on every index
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) rd(3'(i));

        // R2 / R3: field placement and reserved bits
        cur_tag = "R2";
        wr(3'd0, 32'h801F_0010);
        cur_tag = "R3";
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0000_0000);
        cur_tag = "R2";
        wr(3'd2, 32'h0100_8100);
        wr(3'd4, 32'h9FFF_0FFF);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5); rd(3'd6); rd(3'd7);
        rq(24'h000000, 2'd1, 7'd1);

        // R6: inclusive page bounds of range 0
        cur_tag = "R6";
        rq(24'h010000, 2'd1, 7'd1);
        rq(24'h00FFFF, 2'd1, 7'd1);
        rq(24'h01FFFF, 2'd1, 7'd1);
        rq(24'h020000, 2'd1, 7'd1);
        rq(24'hFFFFFF, 2'd1, 7'd1);
        rq(24'hFFF000, 2'd2, 7'd1);
        rq(24'hFFEFFF, 2'd1, 7'd1);

        // R5: kind selects the enable
        cur_tag = "R5";
        rq(24'h010000, 2'd0, 7'd1);
        rq(24'h015000, 2'd2, 7'd1);
        rq(24'h015000, 2'd3, 7'd4);
        rq(24'h100800, 2'd0, 7'd4);
        rq(24'h100800, 2'd1, 7'd4);

        // R7: multi-byte spans and zero length
        cur_tag = "R7";
        rq(24'h00FFF0, 2'd1, 7'd16);
        rq(24'h00FFF0, 2'd1, 7'd17);
        rq(24'h010000, 2'd1, 7'd0);
        rq(24'h01FFF0, 2'd1, 7'd127);
        rq(24'hFFEFF0, 2'd1, 7'd127);
        rq(24'h0FFFC0, 2'd0, 7'd64);

        // R8: inverted window blocks nothing
        cur_tag = "R8";
        wr(3'd3, 32'h8040_8041);
        rq(24'h040FF0, 2'd1, 7'd32);
        rq(24'h040FF0, 2'd0, 7'd32);

        // R10: same-cycle write and request use old contents
        cur_tag = "R10";
        @(negedge clk);
        reg_wr_en  = 1'b1;
        reg_wr_idx = 3'd0;
        reg_wdata  = 32'h0;
        reg_rd_idx = 3'd0;
        req_valid  = 1'b1;
        req_addr   = 24'h010000;
        req_kind   = 2'd1;
        req_len    = 7'd1;
        @(negedge clk);
        reg_wr_en  = 1'b0;
        req_valid  = 1'b0;
        rq(24'h010000, 2'd1, 7'd1);
        wr(3'd0, 32'h801F_0010);

        // R9: lock freezes the bank, including a same-cycle write
        cur_tag = "R9";
        @(negedge clk);
        lock_in    = 1'b1;
        reg_wr_en  = 1'b1;
        reg_wr_idx = 3'd0;
        reg_wdata  = 32'h0;
        @(negedge clk);
        lock_in    = 1'b0;
        reg_wr_en  = 1'b0;
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h1234_5678);
        rq(24'h010000, 2'd1, 7'd1);
        rq(24'h100000, 2'd0, 7'd1);

        // R1: reset clears the bank and releases the lock
        cur_tag = "R1";
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NR; i++) rd(3'(i));
        rq(24'h010000, 2'd1, 7'd1);
        wr(3'd0, 32'h801F_0010);
        rq(24'h010000, 2'd1, 7'd1);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule